// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This controller chooses the low-power state the chip enters when the CPU executes a sleep instruction, and it decides when that state ends. When the sleep request arrives, the block captures the standby-select bit and the module-stop masks. The move itself waits for the end of the current bus cycle. If every peripheral is stopped (the 8-bit timer may be left out), and the all-clocks-stop enable bit is set, the deepest peripheral-clock-stop state is chosen. Otherwise the block enters plain sleep, or software standby when standby-select is set.

Wake requests come from NMI, eight IRQ pins and the internal 8-bit timer and watchdog. Each request is qualified by the global interrupt disable, by the CPU mask for maskable sources, and by whether the source is routed to the data-transfer controller. An accepted wake passes through a one-cycle exception state before normal operation resumes. A low level on the hardware-standby pin overrides everything, and only reset leaves that state. The block drives clock-gate enables for the peripherals, the bus controller, the I/O ports, the 8-bit timer and the watchdog.

Top module: `lpm_ctrl`

## Requirements
- R1: Mode encoding is normal=0, sleep=1, all-clocks-stop=2, software standby=3, hardware standby=4, exception=5. After reset the mode is 0, every clock enable is 1 and wake_pulse is 0.
- R2: All-clocks-stop (2) is entered only when all of these hold: acs_en=1, sby_sel=0, stop_ext=16'hFFFF, and stop_main is 16'hFFFF or 16'hFFFE.
- R3: With sby_sel=0 and the R2 conditions not met, the block enters sleep (1). With sby_sel=1 it enters software standby (3). sby_sel and the masks are taken in the cycle sleep_req is high, and later changes have no effect.
- R4: The mode leaves normal only on a clock edge where bus_end is high, either in the same cycle as sleep_req or after it. Until then the mode stays 0.
- R5: Clock enables by mode. In 0, 5 and 1 all enables are 1. In 2, periph/bus/io are 0, the watchdog enable is 1, and the timer enable is the inverse of stop_main[0]. In 3 and 4 all enables are 0.
- R6: In modes 1, 2 and 3, NMI or an IRQ pin wakes the block. The timer or watchdog request wakes it only while that source's clock enable is 1. A wake moves the mode to 5 for exactly one cycle, with wake_pulse=1, and then to 0.
- R7: A wake request is ignored when int_disable=1. An IRQ, timer or watchdog request is ignored when irq_mask=1, but NMI still wakes. A source whose dtc_route bit is 1 is ignored (bits 7..0 = IRQ7..IRQ0, bit 8 = timer, bit 9 = watchdog).
- R8: hstby_n=0 forces mode 4 at the next edge from any mode. Mode 4 holds after hstby_n returns high, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| stop_main | input | 16 | Main module-stop mask, bit 0 = 8-bit timer |
| stop_ext | input | 16 | Extended module-stop mask |
| acs_en | input | 1 | All-clocks-stop enable |
| sby_sel | input | 1 | Standby-select bit |
| sleep_req | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | End of bus cycle strobe |
| nmi | input | 1 | Non-maskable interrupt pin |
| irq | input | 8 | IRQ pins |
| tmr8_wake | input | 1 | 8-bit timer interrupt request |
| wdt_wake | input | 1 | Watchdog interrupt request |
| hstby_n | input | 1 | Hardware standby pin, active low |
| int_disable | input | 1 | Global interrupt disable |
| irq_mask | input | 1 | CPU mask of non-NMI interrupts |
| dtc_route | input | 10 | Per-source transfer-controller routing flags |
| mode | output | 3 | Current mode |
| periph_clk_en | output | 1 | Peripheral clock enable |
| bus_clk_en | output | 1 | Bus controller clock enable |
| io_clk_en | output | 1 | I/O port clock enable |
| tmr8_clk_en | output | 1 | 8-bit timer clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| wake_pulse | output | 1 | One-cycle exception/wake pulse |

## Verification
The mode register drives all clock enables and the wake pulse directly, so a wrong internal state is visible on the ports within the cycle after the edge that caused it. If the captured target or the pending flag is wrong, the fault shows one cycle after bus_end, as the wrong mode code and a wrong enable pattern. A bad wake qualification shows as a missing or unwanted exception pulse one cycle after the request. The bench samples at the falling edge to catch each of these.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int MASK_W = 16,
  parameter int IRQ_N  = 8,
  localparam int SRC_N = IRQ_N + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] stop_main,
  input  logic [MASK_W-1:0] stop_ext,
  input  logic              acs_en,
  input  logic              sby_sel,
  input  logic              sleep_req,
  input  logic              bus_end,
  input  logic              nmi,
  input  logic [IRQ_N-1:0]  irq,
  input  logic              tmr8_wake,
  input  logic              wdt_wake,
  input  logic              hstby_n,
  input  logic              int_disable,
  input  logic              irq_mask,
  input  logic [SRC_N-1:0]  dtc_route,
  output logic [2:0]        mode,
  output logic              periph_clk_en,
  output logic              bus_clk_en,
  output logic              io_clk_en,
  output logic              tmr8_clk_en,
  output logic              wdt_clk_en,
  output logic              wake_pulse
);

  typedef enum logic [2:0] {
    M_NORM = 3'd0, M_SLEEP = 3'd1, M_ACS = 3'd2,
    M_SSTBY = 3'd3, M_HSTBY = 3'd4, M_EXC = 3'd5
  } mode_t;

  mode_t st, tgt, req_tgt, go_tgt;
  logic  pend, go, acs_ok, run, lowp, wake;
  logic [IRQ_N-1:0] irq_ok;
  logic  tmr_ok, wdt_ok;

  assign acs_ok  = acs_en && (&stop_ext) && (&stop_main[MASK_W-1:1]);
  assign req_tgt = sby_sel ? M_SSTBY : (acs_ok ? M_ACS : M_SLEEP);
  assign go_tgt  = sleep_req ? req_tgt : tgt;
  assign go      = (sleep_req || pend) && bus_end;

  assign run  = (st == M_NORM) || (st == M_EXC) || (st == M_SLEEP);
  assign lowp = (st == M_SLEEP) || (st == M_ACS) || (st == M_SSTBY);

  assign periph_clk_en = run;
  assign bus_clk_en    = run;
  assign io_clk_en     = run;
  assign wdt_clk_en    = run || (st == M_ACS);
  assign tmr8_clk_en   = run || ((st == M_ACS) && !stop_main[0]);
  assign wake_pulse    = (st == M_EXC);
  assign mode          = st;

  assign irq_ok = irq & ~dtc_route[IRQ_N-1:0] & {IRQ_N{~irq_mask}};
  assign tmr_ok = tmr8_wake && !dtc_route[IRQ_N]   && !irq_mask && tmr8_clk_en;
  assign wdt_ok = wdt_wake  && !dtc_route[IRQ_N+1] && !irq_mask && wdt_clk_en;
  assign wake   = !int_disable && (nmi || (|irq_ok) || tmr_ok || wdt_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= M_NORM;
      tgt  <= M_SLEEP;
      pend <= 1'b0;
    end else if (!hstby_n) begin
      st   <= M_HSTBY;
      pend <= 1'b0;
    end else begin
      case (st)
        M_NORM: begin
          if (go) begin
            st   <= go_tgt;
            pend <= 1'b0;
          end else if (sleep_req) begin
            pend <= 1'b1;
            tgt  <= req_tgt;
          end
        end
        M_SLEEP, M_ACS, M_SSTBY: if (wake) st <= M_EXC;
        M_EXC:   st <= M_NORM;
        M_HSTBY: st <= M_HSTBY;
        default: st <= M_NORM;
      endcase
    end
  end

  // R8
  hstby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hstby_n |=> (mode == 3'd4));

  // R8
  hstby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> (mode == 3'd4));

  // R6
  exc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && hstby_n) |=> (mode == 3'd0 && !wake_pulse));

  // R6
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(mode) == 3'd1 || $past(mode) == 3'd2 || $past(mode) == 3'd3));

  // R4
  wait_bus_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !bus_end && hstby_n) |=> (mode == 3'd0));

  // R7
  disabled_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lowp && int_disable && hstby_n) |=> $stable(mode));

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] stop_main = 16'hFFFF, stop_ext = 16'hFFFF;
  logic acs_en = 1'b1, sby_sel = 1'b0, sleep_req = 1'b0, bus_end = 1'b0;
  logic nmi = 1'b0, tmr8_wake = 1'b0, wdt_wake = 1'b0, hstby_n = 1'b1;
  logic int_disable = 1'b0, irq_mask = 1'b0;
  logic [7:0] irq = '0;
  logic [9:0] dtc_route = '0;
  logic [2:0] mode;
  logic periph_clk_en, bus_clk_en, io_clk_en, tmr8_clk_en, wdt_clk_en, wake_pulse;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  lpm_ctrl dut (.*);

  // {stop_main, stop_ext, acs_en, sby_sel, expected mode}
  localparam logic [36:0] VEC [0:5] = '{
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 3'd2},
    {16'hFFFE, 16'hFFFF, 1'b1, 1'b0, 3'd2},
    {16'hFFFD, 16'hFFFF, 1'b1, 1'b0, 3'd1},
    {16'hFFFF, 16'hFFFE, 1'b1, 1'b0, 3'd1},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 3'd1},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 3'd3}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // enables {periph,bus,io,tmr8,wdt} expected for a mode (R5)
  function automatic logic [4:0] exp_en(input logic [2:0] m, input logic sm0);
    case (m)
      3'd0, 3'd1, 3'd5: return 5'b11111;
      3'd2:             return {3'b000, ~sm0, 1'b1};
      default:          return 5'b00000;
    endcase
  endfunction

  function automatic logic [4:0] en_now();
    return {periph_clk_en, bus_clk_en, io_clk_en, tmr8_clk_en, wdt_clk_en};
  endfunction

  task automatic enter(input logic [15:0] sm, input logic [15:0] se, input logic a, input logic s);
    @(negedge clk);
    stop_main = sm; stop_ext = se; acs_en = a; sby_sel = s; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R4 waits for bus end", {5'd0, mode}, 8'd0);
    @(negedge clk);
    bus_end = 1'b1;
    @(negedge clk);
    bus_end = 1'b0;
  endtask

  task automatic expect_wake(input string tag);
    @(negedge clk);
    chk(tag, {5'd0, mode}, 8'd5);
    chk("R6 wake pulse", {7'd0, wake_pulse}, 8'd1);
    @(negedge clk);
    chk("R6 back to normal", {5'd0, mode}, 8'd0);
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", {5'd0, mode}, 8'd0);
    chk("R1 reset enables", {3'd0, en_now()}, 8'h1F);
    chk("R1 reset pulse", {7'd0, wake_pulse}, 8'd0);

    // R2 R3 R5 R6 table walk
    for (int i = 0; i < 6; i++) begin
      enter(VEC[i][36:21], VEC[i][20:5], VEC[i][4], VEC[i][3]);
      chk($sformatf("R2/R3 vec%0d mode", i), {5'd0, mode}, {5'd0, VEC[i][2:0]});
      chk($sformatf("R5 vec%0d enables", i), {3'd0, en_now()}, {3'd0, exp_en(VEC[i][2:0], VEC[i][21])});
      @(negedge clk); nmi = 1'b1;
      expect_wake("R6 nmi wake");
      nmi = 1'b0;
    end

    // R4 request and bus end in the same cycle
    @(negedge clk);
    stop_main = 16'hFFFF; stop_ext = 16'hFFFF; acs_en = 1'b1; sby_sel = 1'b0;
    sleep_req = 1'b1; bus_end = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; bus_end = 1'b0;
    chk("R4 same cycle entry", {5'd0, mode}, 8'd2);
    pulse_nmi(); @(negedge clk);

    // R3 standby-select taken at request time
    @(negedge clk); sby_sel = 1'b1; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0; sby_sel = 1'b0;
    @(negedge clk); bus_end = 1'b1;
    @(negedge clk); bus_end = 1'b0;
    chk("R3 sby sampled 1", {5'd0, mode}, 8'd3);
    pulse_nmi(); @(negedge clk);
    @(negedge clk); sby_sel = 1'b0; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0; sby_sel = 1'b1;
    @(negedge clk); bus_end = 1'b1;
    @(negedge clk); bus_end = 1'b0; sby_sel = 1'b0;
    chk("R3 sby sampled 0", {5'd0, mode}, 8'd2);

    // R7 global disable blocks NMI
    @(negedge clk); int_disable = 1'b1; nmi = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 disabled nmi ignored", {5'd0, mode}, 8'd2);
    nmi = 1'b0; int_disable = 1'b0;

    // R7 masked irq ignored, routed irq ignored, plain irq wakes
    @(negedge clk); irq_mask = 1'b1; irq = 8'h08;
    @(negedge clk); @(negedge clk);
    chk("R7 masked irq ignored", {5'd0, mode}, 8'd2);
    irq_mask = 1'b0; dtc_route = 10'h008;
    @(negedge clk); @(negedge clk);
    chk("R7 routed irq ignored", {5'd0, mode}, 8'd2);
    dtc_route = 10'h000;
    expect_wake("R6 irq3 wake");
    irq = 8'h00;

    // R7 NMI wakes despite mask
    enter(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    chk("R3 sleep entry", {5'd0, mode}, 8'd1);
    @(negedge clk); irq_mask = 1'b1; nmi = 1'b1;
    expect_wake("R7 nmi passes mask");
    nmi = 1'b0; irq_mask = 1'b0;

    // R6 watchdog wakes all-clocks-stop; timer ignored when stopped
    enter(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    @(negedge clk); tmr8_wake = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 stopped timer ignored", {5'd0, mode}, 8'd2);
    tmr8_wake = 1'b0; wdt_wake = 1'b1;
    expect_wake("R6 watchdog wake");
    wdt_wake = 1'b0;

    // R6 running timer wakes all-clocks-stop
    enter(16'hFFFE, 16'hFFFF, 1'b1, 1'b0);
    @(negedge clk); tmr8_wake = 1'b1;
    expect_wake("R6 timer wake");
    tmr8_wake = 1'b0;

    // R6 internal sources ignored in software standby
    enter(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
    @(negedge clk); wdt_wake = 1'b1; tmr8_wake = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 standby ignores internal", {5'd0, mode}, 8'd3);
    wdt_wake = 1'b0; tmr8_wake = 1'b0;
    pulse_nmi(); @(negedge clk);

    // R8 hardware standby
    @(negedge clk); hstby_n = 1'b0;
    @(negedge clk);
    chk("R8 hstby forced", {5'd0, mode}, 8'd4);
    chk("R5 hstby enables", {3'd0, en_now()}, 8'h00);
    hstby_n = 1'b1; nmi = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 hstby holds", {5'd0, mode}, 8'd4);
    nmi = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset leaves hstby", {5'd0, mode}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule